// File: doc/BRIEF.md
# Wake and Bus-Isolation Power Controller

This block runs the low-power side of a network interface that sits on a shared host bus. It runs on an always-on clock that keeps going while the host bus is unpowered. It reads an auxiliary-power strap while a reset is active and keeps that reading as a flag. Configuration logic outside this block uses the flag to choose the value it reports in its power-management capability field.

When the host bus loses power, the block cuts every bus output driver. It also ignores the bus reset and the clear strobe that arrive from the bus side. The wake request pin is the one exception: it keeps working during isolation.

The wake policy depends on the current device power state and on the link. The block watches the synchronized link-valid input for edges and looks for packet-match pulses. It records every qualified event in a sticky status bit. The wake request pin is an open-drain output: it pulls low while the status bit and the wake enable are both set.

Top module: `pm_wake_ctrl`

## Requirements
- R1: `aux_pwr` takes the value of `strap_aux` at every clock edge while `por_n` is low, or while `bus_rst_n` is low and the bus is powered (synchronized `pwr_good` high). At all other times it holds its value. A bus reset that arrives during isolation does not sample the strap.
- R2: While `por_n` is low, `wake_sts`, `pme_drive` and `bus_oe` are 0, and the two synchronizers and the link history are cleared.
- R3: `bus_oe` falls no later than 2 clock edges after `pwr_good` falls. While isolated, `sts_clr` has no effect on `wake_sts`.
- R4: After `pwr_good` rises, `bus_oe` rises on the 3rd clock edge, provided `bus_rst_n` is high. It stays low for as long as `bus_rst_n` is held low, and rises on the first edge after `bus_rst_n` is seen high.
- R5: The uninitialized full-power state (`pstate`=0, `d0_active`=0) raises no wake event for link edges or packets.
- R6: In the active full-power state (`pstate`=0, `d0_active`=1), each link-valid edge in either direction sets `wake_sts` even when `wake_en` is 0. Packet matches are ignored in this state.
- R7: In `pstate` 1, 2 and 3 (D1, D2, D3) with `wake_en`=1, the following set `wake_sts`: a packet match while the link is valid, loss of link, and gain of link. A packet match while the link is invalid does not set it.
- R8: In `pstate` 1 to 3 with `wake_en`=0, no event sets `wake_sts`.
- R9: `wake_sts` is sticky. Bus reset does not clear it. A `sts_clr` pulse on a powered bus clears it. An event in the same cycle as a clear wins, and the bit stays set.
- R10: `pme_drive` (1 = pull the open-drain wake pin low) equals `wake_sts` AND `wake_en`, including while the bus is isolated.
- R11: `link_up` passes through a 2-flop synchronizer. A link edge sets `wake_sts` on the 3rd clock edge after the change, and each edge raises exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on (alternate) reset, active low, asynchronous |
| bus_rst_n | input | 1 | Host bus reset, active low |
| strap_aux | input | 1 | Auxiliary-power strap pin |
| pwr_good | input | 1 | Bus power-good (isolate when low), asynchronous |
| pstate | input | 2 | Device power state: 0=D0, 1=D1, 2=D2, 3=D3 |
| d0_active | input | 1 | In D0: 1 = active (initialized), 0 = uninitialized |
| wake_en | input | 1 | Wake request enable |
| link_up | input | 1 | Link valid, asynchronous |
| pkt_match | input | 1 | One-cycle pulse on a matched packet |
| sts_clr | input | 1 | Write-one-to-clear strobe for the wake status |
| aux_pwr | output | 1 | Latched auxiliary-power flag |
| bus_oe | output | 1 | Bus output driver enable |
| pme_drive | output | 1 | Open-drain wake pin pull-down enable |
| wake_sts | output | 1 | Sticky wake status |

## Verification
Two things can happen in the same clock edge: a wake event setting the status bit, and a software clear removing it. The bench provokes the collision by driving a packet-match pulse and the clear strobe in one cycle while the block is in D1 with the link valid. It expects the status bit to be set afterwards and to stay set in the next cycle. A second collision is a wake event arriving during bus isolation. There the event must be recorded and the wake pin pulled, while `bus_oe` stays low and the clear strobe is ignored.

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       bus_rst_n,
  input  logic       strap_aux,
  input  logic       pwr_good,
  input  logic [1:0] pstate,
  input  logic       d0_active,
  input  logic       wake_en,
  input  logic       link_up,
  input  logic       pkt_match,
  input  logic       sts_clr,
  output logic       aux_pwr,
  output logic       bus_oe,
  output logic       pme_drive,
  output logic       wake_sts
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] pg_sync, lk_sync;
  logic         lk_prev, bus_ok, sts_q, aux_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pg_sync <= '0;
      lk_sync <= '0;
      lk_prev <= 1'b0;
    end else begin
      pg_sync <= {pg_sync[TOP-1:0], pwr_good};
      lk_sync <= {lk_sync[TOP-1:0], link_up};
      lk_prev <= lk_sync[TOP];
    end

  wire pg_ok   = pg_sync[TOP];
  wire lk_now  = lk_sync[TOP];
  wire lk_edge = lk_now ^ lk_prev;
  wire bus_rst = pg_ok & ~bus_rst_n;
  wire clr_ok  = pg_ok & sts_clr;

  wire evt = (pstate == 2'd0) ? (d0_active & lk_edge)
                              : (wake_en & (lk_edge | (pkt_match & lk_now)));

  always_ff @(posedge clk)
    if (!por_n || bus_rst) aux_q <= strap_aux;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      bus_ok <= 1'b0;
    else             bus_ok <= pg_ok & bus_rst_n;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      sts_q <= 1'b0;
    else if (evt)    sts_q <= 1'b1;
    else if (clr_ok) sts_q <= 1'b0;

  assign aux_pwr   = aux_q;
  assign bus_oe    = bus_ok & pg_ok;
  assign wake_sts  = sts_q;
  assign pme_drive = sts_q & wake_en;

  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rst_n || !pg_ok) |=> $stable(aux_pwr));                           // R1
  AST_OE_AFTER_RST: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bus_oe) |-> $past(bus_rst_n));                                    // R4
  AST_ISO_OE_LOW: assert property (@(posedge clk) disable iff (!por_n)
    $past(!pg_ok) && !pg_ok |-> !bus_oe);                                  // R3
  AST_D0U_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (!wake_sts && pstate == 2'd0 && !d0_active) |=> !wake_sts);            // R5
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!por_n)
    (!wake_sts && pstate != 2'd0 && !wake_en) |=> !wake_sts);              // R8
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (wake_sts && !sts_clr) |=> wake_sts);                                  // R9
  AST_PME_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
    pme_drive |-> wake_en);                                                // R10

endmodule

// File: tb/pm_wake_ctrl_tb.sv
module pm_wake_ctrl_tb;
  logic clk = 0, por_n = 0, bus_rst_n = 1, strap_aux = 1, pwr_good = 0;
  logic [1:0] pstate = 0;
  logic d0_active = 0, wake_en = 0, link_up = 0, pkt_match = 0, sts_clr = 0;
  logic aux_pwr, bus_oe, pme_drive, wake_sts;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_wake_ctrl u_dut (.clk, .por_n, .bus_rst_n, .strap_aux, .pwr_good, .pstate,
    .d0_active, .wake_en, .link_up, .pkt_match, .sts_clr,
    .aux_pwr, .bus_oe, .pme_drive, .wake_sts);

  // {pstate[1:0], d0_active, wake_en, link_before, link_after, pkt, exp_sts}
  localparam logic [7:0] VEC [15] = '{
    8'b00_0_1_0_1_0_0,  // R5 D0u link rise
    8'b00_0_1_1_0_0_0,  // R5 D0u link fall
    8'b00_1_0_0_1_0_1,  // R6 D0a rise, enable off
    8'b00_1_0_1_0_0_1,  // R6 D0a fall
    8'b00_1_1_1_1_1_0,  // R6 D0a packet ignored
    8'b01_0_1_1_1_1_1,  // R7 D1 packet, link valid
    8'b01_0_1_1_0_0_1,  // R7 D1 loss of link
    8'b01_0_1_0_1_0_1,  // R7 D1 gain of link
    8'b01_0_1_0_0_1_0,  // R7 D1 packet, link invalid
    8'b01_0_0_1_0_0_0,  // R8 D1 disabled
    8'b10_0_1_1_1_1_1,  // R7 D2 packet
    8'b10_0_1_0_0_1_0,  // R7 D2 packet, no link
    8'b11_0_1_0_1_0_1,  // R7 D3 gain of link
    8'b11_0_0_1_1_1_0,  // R8 D3 disabled
    8'b11_0_1_1_0_0_1   // R7 D3 loss of link
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_sts();
    sts_clr = 1; cyc(1); sts_clr = 0;
  endtask

  initial begin
    cyc(3);
    chk("R2 wake_sts in reset", wake_sts, 0);
    chk("R2 pme_drive in reset", pme_drive, 0);
    chk("R2 bus_oe in reset", bus_oe, 0);
    chk("R1 strap sampled by por", aux_pwr, 1);
    por_n = 1; cyc(1); strap_aux = 0; cyc(2);
    chk("R1 strap held after reset", aux_pwr, 1);

    // isolated: bus reset must not sample strap
    bus_rst_n = 0; cyc(3);
    chk("R1 bus reset ignored while isolated", aux_pwr, 1);
    chk("R4 oe low while isolated", bus_oe, 0);
    pwr_good = 1; cyc(4);
    chk("R1 bus reset samples strap", aux_pwr, 0);
    chk("R4 oe held by bus reset", bus_oe, 0);
    bus_rst_n = 1; strap_aux = 1; cyc(1);
    chk("R4 oe after reset release", bus_oe, 1);
    chk("R1 strap held after bus reset", aux_pwr, 0);

    // restoration latency with bus reset high
    pwr_good = 0; cyc(1);
    chk("R3 oe before sync", bus_oe, 1);
    cyc(1);
    chk("R3 oe falls after 2 edges", bus_oe, 0);
    pwr_good = 1; cyc(2);
    chk("R4 oe low at 2nd edge", bus_oe, 0);
    cyc(1);
    chk("R4 oe high at 3rd edge", bus_oe, 1);

    // vector table
    foreach (VEC[i]) begin
      logic [7:0] v;
      v = VEC[i];
      pstate = v[7:6]; d0_active = v[5]; wake_en = v[4]; link_up = v[3];
      cyc(5); clear_sts(); cyc(1);
      if (v[1]) begin pkt_match = 1; cyc(1); pkt_match = 0; end
      else link_up = v[2];
      cyc(4);
      chk($sformatf("R5/R6/R7/R8 vector %0d sts", i), wake_sts, v[0]);
      chk($sformatf("R10 vector %0d pme", i), pme_drive, v[0] & v[4]);
    end

    // R11 latency and single event per edge
    pstate = 1; d0_active = 0; wake_en = 1; link_up = 0; cyc(5); clear_sts();
    link_up = 1; cyc(2);
    chk("R11 no event at 2nd edge", wake_sts, 0);
    cyc(1);
    chk("R11 event at 3rd edge", wake_sts, 1);
    clear_sts(); cyc(4);
    chk("R11 one event per edge", wake_sts, 0);

    // R9 set wins over clear
    pkt_match = 1; sts_clr = 1; cyc(1); pkt_match = 0; sts_clr = 0;
    chk("R9 set wins over clear", wake_sts, 1);
    cyc(1);
    chk("R9 stays set", wake_sts, 1);
    bus_rst_n = 0; cyc(3); bus_rst_n = 1; cyc(1);
    chk("R9 bus reset keeps status", wake_sts, 1);
    clear_sts();
    chk("R9 clear strobe", wake_sts, 0);

    // wake during isolation
    pwr_good = 0; cyc(3);
    pkt_match = 1; cyc(1); pkt_match = 0; cyc(1);
    chk("R10 wake recorded while isolated", wake_sts, 1);
    chk("R10 pme pulled while isolated", pme_drive, 1);
    chk("R3 oe low while isolated", bus_oe, 0);
    clear_sts(); cyc(1);
    chk("R3 clear ignored while isolated", wake_sts, 1);
    wake_en = 0; cyc(1);
    chk("R10 pme off with enable off", pme_drive, 0);

    // por clears sticky state
    por_n = 0; #1;
    chk("R2 por clears status", wake_sts, 0);
    cyc(2); por_n = 1; cyc(1);
    chk("R2 oe low after por", bus_oe, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule